// File: doc/BRIEF.md
# Transmit Packet Buffer Handoff Controller

This block arbitrates ownership of a single transmit packet buffer that two sides share. On one side a CPU writes bytes one at a time through a FIFO write port and uses a 16-bit control/status word. On the other side a serial interface engine (SIE) reads the stored bytes and sends them as a packet. The CPU fills the buffer and then marks it valid. The block then locks the CPU out and presents the buffer and its byte count to the SIE. When the SIE reports with a one-cycle pulse that the packet has gone, the buffer returns empty to the CPU.

Short packets, zero-length packets and a continuous transfer mode are supported. In continuous mode the CPU may still hand over any whole multiple of the maximum packet size by hand. The block also hands the buffer over by itself as soon as it holds the largest whole multiple of the maximum packet size that fits the buffer. Writes to the valid flag are honoured only while the CPU side owns the buffer, and only when the pipe direction is transmit.

The control/status word has this layout:
- Bit 15 is the valid flag (read/write).
- Bit 14 is the clear command. It accepts writes only and always reads 0.
- Bit 13 is the ready flag (read-only).
- Bit 12 is reserved and reads 0.
- Bits 11:0 hold the count of bytes held (read-only).

Top module: `txbuf_handoff`

## Requirements
- R1: While reset is asserted, and until the first clock edge after it is released, the status word reads 0x0000. From that edge on it reads 0x2000: ready is set, and the reserved bit 12 and the clear bit 14 always read 0.
- R2: A byte written while ready is set and the buffer is not full is stored at the address equal to the count before the write, and the count in bits 11:0 rises by one at the next edge.
- R3: A register write with bit 15 set, made while ready is set and the direction is transmit, causes the following at the next edge: bit 15 reads 1, bit 13 reads 0, `sieOwn` is 1, and `sieLen` equals the number of bytes held. `sieRdData` then returns each stored byte at its address.
- R4: Setting bit 15 with no bytes written hands over a buffer with `sieLen` equal to 0.
- R5: In continuous mode, a manual handoff after writing any whole multiple of the maximum packet size below the buffer size hands over exactly that count. The byte that brings the count to the largest whole multiple of the maximum packet size that fits the buffer triggers a handoff at the same edge, with no register write needed.
- R6: A `sieSent` pulse while the SIE owns the buffer makes the status word read 0x2000 and drops `sieOwn` at the next edge.
- R7: A write of bit 15 while ready is 0 has no effect. After the buffer returns, the valid flag reads 0.
- R8: When the direction is receive, writes to bit 15 and the continuous-mode automatic handoff are both ignored. Ready stays 1 and bit 15 stays 0.
- R9: A byte write that is not accepted, either because ready is 0 or because the buffer is full, is dropped and leaves the count unchanged. It sets `overrun`, which stays set until a clear.
- R10: Writing 1 to bit 14 empties the buffer, clears the valid flag and `overrun`, and returns ownership to the CPU at the next edge, whoever owned it before. The clear wins over a bit 15 write in the same word.
- R11: The count saturates at the buffer size. Outside continuous mode a full buffer is not handed over automatically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dirTx | input | 1 | Pipe direction, 1 = transmit |
| contMode | input | 1 | Continuous transfer mode enable |
| regWrEn | input | 1 | Write strobe for the status word |
| regWrData | input | 16 | Status word write data |
| regRdData | output | 16 | Status word read value |
| fifoWrEn | input | 1 | CPU byte write strobe |
| fifoWrData | input | 8 | CPU byte to store |
| overrun | output | 1 | Sticky flag for a dropped byte write |
| sieOwn | output | 1 | Buffer is owned by the SIE |
| sieLen | output | 12 | Byte count handed to the SIE |
| sieRdAddr | input | ADDR_W | SIE byte read address |
| sieRdData | output | 8 | Byte stored at `sieRdAddr` |
| sieSent | input | 1 | One-cycle pulse: packet sent |

## Verification
A wrong ownership state shows up in the status word one edge after the triggering write or pulse. The symptoms are a ready bit that fails to drop or return, a valid bit that sticks after a `sieSent`, or an automatic handoff that comes one byte early or late. A corrupted count shows at once in bits 11:0 and in `sieLen`, and a wrong write pointer shows when the SIE reads back the stored bytes. The bench sweeps every packet length from empty to full and checks each stored byte, so a single misplaced byte or an off-by-one count is caught within that packet.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;
  localparam int LEN_W = 12;

  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_CPU  = 2'd1,
    OWN_SIE  = 2'd2
  } owner_e;

  typedef struct packed {
    logic takeByte;
    logic handOff;
    logic giveBack;
    logic purge;
  } dpStrobes_t;
endpackage

// File: rtl/txbuf_ctrl.sv
module txbuf_ctrl
  import txbuf_pkg::*;
#(
  parameter int MAX_PKT   = 64,
  parameter int BUF_BYTES = 256,
  localparam int CNT_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dirTx,
  input  logic             contMode,
  input  logic             regWrEn,
  input  logic [15:0]      regWrData,
  input  logic             fifoWrEn,
  input  logic             sieSent,
  input  logic [CNT_W-1:0] count,
  output dpStrobes_t       strb,
  output logic [15:0]      regRdData,
  output logic             overrun,
  output logic             sieOwn
);
  localparam int AUTO_LEVEL = (BUF_BYTES / MAX_PKT) * MAX_PKT;
  localparam logic [CNT_W-1:0] AUTO_M1 = CNT_W'(AUTO_LEVEL - 1);
  localparam logic [CNT_W-1:0] FULL    = CNT_W'(BUF_BYTES);

  owner_e owner;
  logic   valid;
  logic   ready;
  logic   clearCmd;
  logic   validCmd;
  logic   accept;
  logic   autoFire;

  assign ready    = (owner == OWN_CPU);
  assign sieOwn   = (owner == OWN_SIE);
  assign clearCmd = regWrEn && regWrData[14];
  assign validCmd = regWrEn && regWrData[15] && ready && dirTx && !clearCmd;
  assign accept   = fifoWrEn && ready && (count < FULL) && !clearCmd;
  assign autoFire = accept && contMode && dirTx && (count == AUTO_M1);

  always_comb begin
    strb          = '0;
    strb.purge    = clearCmd;
    strb.takeByte = accept;
    strb.handOff  = validCmd || autoFire;
    strb.giveBack = sieOwn && sieSent && !clearCmd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      owner   <= OWN_IDLE;
      valid   <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (clearCmd) begin
        owner   <= OWN_CPU;
        valid   <= 1'b0;
        overrun <= 1'b0;
      end else begin
        if (fifoWrEn && !accept) overrun <= 1'b1;
        unique case (owner)
          OWN_IDLE: owner <= OWN_CPU;
          OWN_CPU: if (strb.handOff) begin
            owner <= OWN_SIE;
            valid <= 1'b1;
          end
          OWN_SIE: if (strb.giveBack) begin
            owner <= OWN_CPU;
            valid <= 1'b0;
          end
          default: owner <= OWN_CPU;
        endcase
      end
    end
  end

  assign regRdData = {valid, 1'b0, ready, 1'b0, LEN_W'(count)};

  p_handoff_locks_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.handOff |=> (!ready && valid && sieOwn));

  p_giveback_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.giveBack |=> (ready && !valid));

  p_locked_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (sieOwn && regWrEn && regWrData[15] && !clearCmd && !sieSent) |=> sieOwn);

  p_rx_no_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!dirTx && !valid) |=> !valid);

  p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !clearCmd) |=> overrun);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    clearCmd |=> (ready && !valid && !overrun));
endmodule

// File: rtl/txbuf_datapath.sv
module txbuf_datapath
  import txbuf_pkg::*;
#(
  parameter int BUF_BYTES = 256,
  localparam int CNT_W    = $clog2(BUF_BYTES + 1),
  localparam int ADDR_W   = $clog2(BUF_BYTES),
  localparam int DEPTH    = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strb,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic [CNT_W-1:0]  count,
  output logic [LEN_W-1:0]  sieLen
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (strb.takeByte && !strb.purge) mem[count[ADDR_W-1:0]] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count  <= '0;
      sieLen <= '0;
    end else begin
      if (strb.purge || strb.giveBack) count <= '0;
      else if (strb.takeByte) count <= count + CNT_W'(1);
      if (strb.handOff && !strb.purge)
        sieLen <= LEN_W'(count) + LEN_W'(strb.takeByte);
    end
  end

  assign rdData = mem[rdAddr];

  always_ff @(posedge clk) begin
    if (rstN) p_count_cap_r11: assert (count <= CNT_W'(BUF_BYTES));
  end

  p_count_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.takeByte && !strb.purge && !strb.giveBack) |=> $stable(count));

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.takeByte && !strb.purge) |=> (count == $past(count) + CNT_W'(1)));
endmodule

// File: rtl/txbuf_handoff.sv
module txbuf_handoff
  import txbuf_pkg::*;
#(
  parameter int MAX_PKT   = 64,
  parameter int BUF_BYTES = 256,
  localparam int CNT_W    = $clog2(BUF_BYTES + 1),
  localparam int ADDR_W   = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dirTx,
  input  logic              contMode,
  input  logic              regWrEn,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  input  logic              fifoWrEn,
  input  logic [7:0]        fifoWrData,
  output logic              overrun,
  output logic              sieOwn,
  output logic [11:0]       sieLen,
  input  logic [ADDR_W-1:0] sieRdAddr,
  output logic [7:0]        sieRdData,
  input  logic              sieSent
);
  dpStrobes_t       strb;
  logic [CNT_W-1:0] count;

  txbuf_ctrl #(.MAX_PKT(MAX_PKT), .BUF_BYTES(BUF_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .dirTx(dirTx), .contMode(contMode),
    .regWrEn(regWrEn), .regWrData(regWrData), .fifoWrEn(fifoWrEn),
    .sieSent(sieSent), .count(count), .strb(strb),
    .regRdData(regRdData), .overrun(overrun), .sieOwn(sieOwn)
  );

  txbuf_datapath #(.BUF_BYTES(BUF_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(fifoWrData),
    .rdAddr(sieRdAddr), .rdData(sieRdData), .count(count), .sieLen(sieLen)
  );
endmodule

// File: tb/txbuf_handoff_test.sv
module txbuf_handoff_test;
  localparam int MP   = 8;
  localparam int BB   = 28;
  localparam int AW   = $clog2(BB);
  localparam int AUTO = (BB / MP) * MP;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rstN = 1'b0, dirTx = 1'b1, contMode = 1'b0;
  logic          regWrEn = 1'b0, fifoWrEn = 1'b0, sieSent = 1'b0;
  logic [15:0]   regWrData = '0;
  logic [7:0]    fifoWrData = '0;
  logic [AW-1:0] sieRdAddr = '0;
  logic [15:0]   regRdData;
  logic          overrun, sieOwn;
  logic [11:0]   sieLen;
  logic [7:0]    sieRdData;
  int checks = 0, errors = 0;

  txbuf_handoff #(.MAX_PKT(MP), .BUF_BYTES(BB)) uut (
    .clk(clk), .rstN(rstN), .dirTx(dirTx), .contMode(contMode),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData), .overrun(overrun),
    .sieOwn(sieOwn), .sieLen(sieLen), .sieRdAddr(sieRdAddr),
    .sieRdData(sieRdData), .sieSent(sieSent)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic putByte(input logic [7:0] d);
    @(negedge clk); fifoWrEn = 1'b1; fifoWrData = d;
    @(negedge clk); fifoWrEn = 1'b0;
  endtask

  task automatic regWr(input logic [15:0] v);
    @(negedge clk); regWrEn = 1'b1; regWrData = v;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic sent();
    @(negedge clk); sieSent = 1'b1;
    @(negedge clk); sieSent = 1'b0;
  endtask

  task automatic fill(input int n, input int seed);
    for (int i = 0; i < n; i++) putByte(8'((seed * 7 + i * 13) & 255));
  endtask

  task automatic mainSeq();
    repeat (3) @(negedge clk);
    chk("R1 reset word", 32'(regRdData), 32'h0000);
    rstN = 1'b1;
    #1 chk("R1 before first edge", 32'(regRdData), 32'h0000);
    @(negedge clk);
    chk("R1 after first edge", 32'(regRdData), 32'h2000);
    regWr(16'h1000);
    chk("R1 reserved bit", 32'(regRdData), 32'h2000);

    // Short-packet sweep over every length, empty to full (R2 R3 R4 R6)
    for (int len = 0; len <= BB; len++) begin
      fill(len, len);
      chk("R2 count", 32'(regRdData[11:0]), 32'(len));
      regWr(16'h8000);
      chk("R3 handoff word", 32'(regRdData), 32'h8000 | 32'(len));
      chk("R3 sieOwn", 32'(sieOwn), 32'd1);
      chk(len == 0 ? "R4 zero length" : "R3 sieLen", 32'(sieLen), 32'(len));
      for (int i = 0; i < len; i++) begin
        sieRdAddr = AW'(i);
        #1 chk("R3 byte", 32'(sieRdData), 32'((len * 7 + i * 13) & 255));
      end
      sent();
      chk("R6 returned word", 32'(regRdData), 32'h2000);
      chk("R6 sieOwn", 32'(sieOwn), 32'd0);
    end

    // Continuous mode: manual multiples, then auto handoff (R5)
    contMode = 1'b1;
    for (int k = 0; k * MP < AUTO; k++) begin
      fill(k * MP, k);
      regWr(16'h8000);
      chk("R5 manual multiple", 32'(sieLen), 32'(k * MP));
      sent();
    end
    fill(AUTO - 1, 3);
    chk("R5 not yet", 32'(sieOwn), 32'd0);
    putByte(8'hA5);
    chk("R5 auto handoff", 32'(regRdData), 32'h8000 | 32'(AUTO));
    chk("R5 auto sieLen", 32'(sieLen), 32'(AUTO));
    sieRdAddr = AW'(AUTO - 1);
    #1 chk("R5 last byte", 32'(sieRdData), 32'hA5);

    // Locked buffer (R7 R9)
    putByte(8'h11);
    chk("R9 count frozen", 32'(regRdData[11:0]), 32'(AUTO));
    chk("R9 overrun set", 32'(overrun), 32'd1);
    regWr(16'h8000);
    sent();
    chk("R7 valid not kept", 32'(regRdData), 32'h2000);
    chk("R9 overrun sticky", 32'(overrun), 32'd1);
    regWr(16'h4000);
    chk("R10 overrun cleared", 32'(overrun), 32'd0);

    // Full buffer outside continuous mode (R11 R9)
    contMode = 1'b0;
    fill(BB + 2, 5);
    chk("R11 saturate", 32'(regRdData), 32'h2000 | 32'(BB));
    chk("R11 no auto", 32'(sieOwn), 32'd0);
    chk("R9 full overrun", 32'(overrun), 32'd1);
    regWr(16'h4000);
    chk("R10 clear word", 32'(regRdData), 32'h2000);

    // Receive direction (R8)
    dirTx = 1'b0; contMode = 1'b1;
    fill(AUTO, 6);
    chk("R8 no auto in rx", 32'(regRdData), 32'h2000 | 32'(AUTO));
    regWr(16'h8000);
    chk("R8 valid ignored", 32'(regRdData), 32'h2000 | 32'(AUTO));
    chk("R8 sieOwn", 32'(sieOwn), 32'd0);
    regWr(16'h4000);
    dirTx = 1'b1; contMode = 1'b0;

    // Clear priority and clear while the SIE owns (R10)
    fill(3, 8);
    regWr(16'hC000);
    chk("R10 clear beats valid", 32'(regRdData), 32'h2000);
    chk("R10 no handoff", 32'(sieOwn), 32'd0);
    fill(2, 9);
    regWr(16'h8000);
    chk("R3 two bytes", 32'(sieLen), 32'd2);
    regWr(16'h4000);
    chk("R10 reclaim", 32'(regRdData), 32'h2000);
    chk("R10 sieOwn", 32'(sieOwn), 32'd0);
  endtask

  initial begin
    fork
      mainSeq();
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule